// File: doc/BRIEF.md
# Set-Associative Data Cache with Age-Counter Replacement

This block sits between a processor's word-wide load/store port and a slower line-wide main-memory port. Each word address is split into three parts: a word offset inside the line, a set index and a tag. The tag is compared against every way of the selected set in parallel. A hit is answered in the same cycle and does not touch memory. A miss stalls the processor while the line is fetched, and first writes back a dirty victim if one is being replaced. The returned data is then served from the freshly filled copy.

Every slot carries a small age counter. Touching a slot clears its counter. Every other valid slot in the same set counts up and stops at its maximum value. On a miss, an empty way is used before any valid way. If no way is empty, the way with the oldest age is replaced. A build-time switch chooses the write policy:

- **Write-back:** a write only marks the line modified. Memory sees the line again on eviction or on flush.
- **Write-through:** every write also sends the updated line to memory.

A flush command writes back every modified line and then empties the whole cache.

Top module: `assoc_cache`

## Requirements
- R1: After reset `cpu_ready`, `mem_req` and `flush_busy` are low and every slot is empty, so the first access to any line misses.
- R2: The word offset is `cpu_addr[OFF_W-1:0]` and the set index is the next `SET_W` bits. The tag is the remaining upper bits. The memory line address is `cpu_addr >> OFF_W`. Line word k sits at bits `[k*DATA_W +: DATA_W]`, and a read returns the word that the offset selects.
- R3: When a read, or a write-back-mode write, hits, `cpu_ready` rises in the same cycle as `cpu_valid` and no memory request is made. At most one way of a set ever matches.
- R4: On a miss, `cpu_ready` stays low until exactly one line read from memory has completed. The request is then completed with the fetched data.
- R5: A miss fills the lowest-numbered empty way of its set before any valid way is replaced.
- R6: An access clears the age of the slot it touches. It also increments the age of every other valid slot in that set, saturating at `2**AGE_W-1`. The victim is the way with the largest age, and the lowest way number wins a tie.
- R7: In write-back mode, a write hit updates the cached word and marks the line modified, with no memory write.
- R8: In write-back mode, evicting a modified line writes it to its own line address before the fill. Evicting an unmodified line causes no write.
- R9: In write-back mode, a write miss fetches the line, merges the written word into it and keeps it as modified, without writing memory.
- R10: In write-through mode, every write sends the merged line to memory with one line write. `cpu_ready` is held low until that write is acknowledged. Evictions never write.
- R11: While a flush runs, the processor is not served. Each modified line is written back and every slot is emptied. Unmodified lines cause no memory traffic.
- R12: `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged from the cycle a request starts until the cycle `mem_ack` is seen.
- R13: `cpu_ready` is never high while `cpu_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present; held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| flush_req | input | 1 | One-cycle pulse while idle starts a flush |
| flush_busy | output | 1 | Flush in progress |
| mem_req | output | 1 | Memory line request |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | ADDR_W-OFF_W | Line address |
| mem_wdata | output | DATA_W*WORDS | Line to write |
| mem_rdata | input | DATA_W*WORDS | Line read, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completes the request this cycle |

## Verification
The bench first sweeps every word of sixty-four lines. A broken address split returns the wrong word, and a broken hit path shows up as a stall or as an extra line read on the second word of each line.

Replacement is probed with a sequence that holds one way busy long enough to push the other counters past their ceiling. A counter that wrapped instead of saturating would evict a different way, and the next access would then miss where it should hit. Evictions are driven so that modified and unmodified victims alternate, so a design that dropped a modified line, or wrote back a clean one, changes the memory contents or the write count.

A flush over a mix of modified and clean lines, and a write-through instance that must never write back on eviction, expose a policy wired the wrong way round.

// File: rtl/assoc_cache.sv
module assoc_cache #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 16,
  parameter int SETS       = 4,
  parameter int WAYS       = 4,
  parameter int WORDS      = 2,
  parameter int AGE_W      = 3,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    cpu_valid,
  input  logic                                    cpu_we,
  input  logic [ADDR_W-1:0]                       cpu_addr,
  input  logic [DATA_W-1:0]                       cpu_wdata,
  output logic                                    cpu_ready,
  output logic [DATA_W-1:0]                       cpu_rdata,
  input  logic                                    flush_req,
  output logic                                    flush_busy,
  output logic                                    mem_req,
  output logic                                    mem_we,
  output logic [ADDR_W-$clog2(WORDS)-1:0]         mem_addr,
  output logic [DATA_W*WORDS-1:0]                 mem_wdata,
  input  logic [DATA_W*WORDS-1:0]                 mem_rdata,
  input  logic                                    mem_ack
);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
  localparam int LINE_W = DATA_W * WORDS;
  localparam int SLOTS  = SETS * WAYS;
  localparam int SLOT_W = SET_W + WAY_W;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  typedef enum logic [2:0] {S_IDLE, S_EVICT, S_FILL, S_WTHRU, S_FLUSH} state_t;

  function automatic logic [SLOT_W-1:0] slot_of(input logic [SET_W-1:0] s, input int w);
    return {s, WAY_W'(w)};
  endfunction

  state_t                st;
  logic [SLOTS-1:0]      vld, dty;
  logic [TAG_W-1:0]      tags  [SLOTS];
  logic [AGE_W-1:0]      age   [SLOTS];
  logic [LINE_W-1:0]     lines [SLOTS];
  logic [SLOT_W-1:0]     fidx;

  wire [OFF_W-1:0] off = cpu_addr[OFF_W-1:0];
  wire [SET_W-1:0] set = cpu_addr[OFF_W +: SET_W];
  wire [TAG_W-1:0] tag = cpu_addr[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0]   hitv;
  logic [WAY_W-1:0]  hway, vway;
  logic              found;
  logic [AGE_W-1:0]  best;

  always_comb begin
    hitv  = '0;
    hway  = '0;
    vway  = '0;
    found = 1'b0;
    best  = '0;
    for (int w = 0; w < WAYS; w++)
      hitv[w] = vld[slot_of(set, w)] && (tags[slot_of(set, w)] == tag);
    for (int w = 0; w < WAYS; w++)
      if (hitv[w]) hway = WAY_W'(w);
    for (int w = 0; w < WAYS; w++)
      if (!found && !vld[slot_of(set, w)]) begin
        found = 1'b1;
        vway  = WAY_W'(w);
      end
    if (!found) begin
      best = age[slot_of(set, 0)];
      for (int w = 1; w < WAYS; w++)
        if (age[slot_of(set, w)] > best) begin
          best = age[slot_of(set, w)];
          vway = WAY_W'(w);
        end
    end
  end

  wire               hit  = |hitv;
  wire [SLOT_W-1:0]  hsel = {set, hway};
  wire [SLOT_W-1:0]  vsel = {set, vway};
  wire [LINE_W-1:0]  hline = lines[hsel];

  logic [LINE_W-1:0] merged;
  logic [DATA_W-1:0] rword;
  always_comb begin
    merged = hline;
    rword  = '0;
    for (int k = 0; k < WORDS; k++)
      if (OFF_W'(k) == off) begin
        rword = hline[k*DATA_W +: DATA_W];
        merged[k*DATA_W +: DATA_W] = cpu_wdata;
      end
  end

  wire wt_write  = cpu_we && !WRITE_BACK;
  wire idle_go   = (st == S_IDLE) && cpu_valid && !flush_req;
  wire fl_dirty  = vld[fidx] && dty[fidx];

  assign cpu_ready  = (idle_go && hit && !wt_write) || (st == S_WTHRU && mem_ack);
  assign cpu_rdata  = rword;
  assign flush_busy = (st == S_FLUSH);
  assign mem_req    = (st == S_EVICT) || (st == S_FILL) || (st == S_WTHRU) ||
                      (st == S_FLUSH && fl_dirty);
  assign mem_we     = (st != S_FILL);

  always_comb begin
    case (st)
      S_EVICT: begin mem_addr = {tags[vsel], set};                      mem_wdata = lines[vsel]; end
      S_WTHRU: begin mem_addr = cpu_addr[ADDR_W-1:OFF_W];               mem_wdata = merged;      end
      S_FLUSH: begin mem_addr = {tags[fidx], fidx[SLOT_W-1:WAY_W]};     mem_wdata = lines[fidx]; end
      default: begin mem_addr = cpu_addr[ADDR_W-1:OFF_W];               mem_wdata = '0;          end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      vld  <= '0;
      dty  <= '0;
      fidx <= '0;
      for (int s = 0; s < SLOTS; s++) age[s] <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (flush_req) begin
            st   <= S_FLUSH;
            fidx <= '0;
          end else if (cpu_valid) begin
            if (hit) begin
              if (wt_write) st <= S_WTHRU;
              else if (cpu_we) dty[hsel] <= 1'b1;
            end else begin
              st <= (vld[vsel] && dty[vsel]) ? S_EVICT : S_FILL;
            end
          end
        S_EVICT:
          if (mem_ack) begin
            dty[vsel] <= 1'b0;
            st        <= S_FILL;
          end
        S_FILL:
          if (mem_ack) begin
            vld[vsel] <= 1'b1;
            dty[vsel] <= 1'b0;
            st        <= S_IDLE;
          end
        S_WTHRU:
          if (mem_ack) st <= S_IDLE;
        S_FLUSH:
          if (!fl_dirty || mem_ack) begin
            vld[fidx] <= 1'b0;
            dty[fidx] <= 1'b0;
            if (fidx == SLOT_W'(SLOTS - 1)) st <= S_IDLE;
            else fidx <= fidx + SLOT_W'(1);
          end
        default: st <= S_IDLE;
      endcase
      if (cpu_ready)
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == hway)
            age[slot_of(set, w)] <= '0;
          else if (vld[slot_of(set, w)] && age[slot_of(set, w)] != AGE_MAX)
            age[slot_of(set, w)] <= age[slot_of(set, w)] + AGE_W'(1);
        end
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_FILL && mem_ack) begin
      tags[vsel]  <= tag;
      lines[vsel] <= mem_rdata;
    end
    if (cpu_ready && cpu_we)
      lines[hsel] <= merged;
  end

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_ready_needs_valid_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_valid);

  assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hitv));

  assert_touch_clears_age_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> age[$past(hsel)] == '0);

  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_busy) |-> vld == '0);
endmodule

// File: tb/assoc_cache_test.sv
module assoc_cache_mem #(
  parameter int LA_W   = 11,
  parameter int DATA_W = 16,
  parameter int LAT    = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic                  we,
  input  logic [LA_W-1:0]       addr,
  input  logic [2*DATA_W-1:0]   wdata,
  output logic [2*DATA_W-1:0]   rdata,
  output logic                  ack,
  output int                    reads,
  output int                    writes,
  output int                    viol
);
  logic [2*DATA_W-1:0] mem [2**LA_W];
  int cnt;
  logic pend;
  logic [LA_W-1:0] paddr;

  function automatic logic [DATA_W-1:0] seed(input int a);
    return DATA_W'(a * 37 + 5) ^ DATA_W'(16'h5A00);
  endfunction

  assign rdata = mem[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack <= 1'b0; cnt <= 0; reads <= 0; writes <= 0; viol <= 0; pend <= 1'b0; paddr <= '0;
      for (int l = 0; l < 2**LA_W; l++) mem[l] <= {seed(2*l+1), seed(2*l)};
    end else begin
      pend  <= req && !ack;
      paddr <= addr;
      if (pend && (!req || addr != paddr)) viol <= viol + 1;
      if (ack) begin
        ack <= 1'b0;
        cnt <= 0;
        if (we) begin mem[addr] <= wdata; writes <= writes + 1; end
        else reads <= reads + 1;
      end else if (req) begin
        if (cnt == LAT) ack <= 1'b1;
        else cnt <= cnt + 1;
      end
    end
  end
endmodule

module assoc_cache_test;
  localparam int AW = 12, DW = 16, LAW = 11, LW = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, we;
  logic [1:0] cv, fr;
  logic [AW-1:0] addr;
  logic [DW-1:0] wd;
  logic [1:0] rdy, busy, mreq, mwe, mack;
  logic [DW-1:0] rd [2];
  logic [LAW-1:0] maddr [2];
  logic [LW-1:0] mwd [2], mrd [2];
  int rcnt [2], wcnt [2], viol [2];

  assoc_cache #(.WRITE_BACK(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cv[0]), .cpu_we(we), .cpu_addr(addr),
    .cpu_wdata(wd), .cpu_ready(rdy[0]), .cpu_rdata(rd[0]), .flush_req(fr[0]),
    .flush_busy(busy[0]), .mem_req(mreq[0]), .mem_we(mwe[0]), .mem_addr(maddr[0]),
    .mem_wdata(mwd[0]), .mem_rdata(mrd[0]), .mem_ack(mack[0]));

  assoc_cache #(.WRITE_BACK(1'b0)) uut_wt (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cv[1]), .cpu_we(we), .cpu_addr(addr),
    .cpu_wdata(wd), .cpu_ready(rdy[1]), .cpu_rdata(rd[1]), .flush_req(fr[1]),
    .flush_busy(busy[1]), .mem_req(mreq[1]), .mem_we(mwe[1]), .mem_addr(maddr[1]),
    .mem_wdata(mwd[1]), .mem_rdata(mrd[1]), .mem_ack(mack[1]));

  assoc_cache_mem #(.LAT(2)) m0 (
    .clk(clk), .rst_n(rst_n), .req(mreq[0]), .we(mwe[0]), .addr(maddr[0]), .wdata(mwd[0]),
    .rdata(mrd[0]), .ack(mack[0]), .reads(rcnt[0]), .writes(wcnt[0]), .viol(viol[0]));

  assoc_cache_mem #(.LAT(1)) m1 (
    .clk(clk), .rst_n(rst_n), .req(mreq[1]), .we(mwe[1]), .addr(maddr[1]), .wdata(mwd[1]),
    .rdata(mrd[1]), .ack(mack[1]), .reads(rcnt[1]), .writes(wcnt[1]), .viol(viol[1]));

  int checks = 0, fails = 0;
  int q, n, dr, dw;

  function automatic int seed(input int a);
    return int'(DW'(a * 37 + 5) ^ DW'(16'h5A00));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input int i, input bit w, input int a, input int d);
    int r0, w0;
    @(negedge clk);
    r0 = rcnt[i]; w0 = wcnt[i];
    addr = AW'(a); we = w; wd = DW'(d); cv[i] = 1'b1; n = 0;
    #1;
    while (!rdy[i]) begin
      @(negedge clk); #1; n++;
      if (n > 500) begin chk("R4 request never completed", n, 0); break; end
    end
    q = int'(rd[i]);
    @(posedge clk); #1;
    cv[i] = 1'b0;
    dr = rcnt[i] - r0; dw = wcnt[i] - w0;
  endtask

  task automatic do_flush(input int i);
    int w0, k;
    @(negedge clk);
    w0 = wcnt[i]; fr[i] = 1'b1;
    @(posedge clk); #1;
    fr[i] = 1'b0;
    chk("R11 busy after flush start", int'(busy[i]), 1);
    k = 0;
    while (busy[i]) begin
      @(negedge clk); k++;
      if (k > 1000) begin chk("R11 flush never ended", k, 0); break; end
    end
    dw = wcnt[i] - w0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cv = '0; fr = '0; we = 1'b0; addr = '0; wd = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ready in reset", int'(rdy), 0);
    chk("R1 mem_req in reset", int'(mreq), 0);
    chk("R1 busy in reset", int'(busy), 0);
    @(negedge clk); rst_n = 1'b1;

    for (int l = 0; l < 64; l++) begin
      acc(0, 0, 2*l, 0);
      chk("R2 word0 data", q, seed(2*l));
      chk("R4 miss stalls", int'(n > 0), 1);
      chk("R4 one line read (R1 empty)", dr, 1);
      acc(0, 0, 2*l+1, 0);
      chk("R2 word1 data", q, seed(2*l+1));
      chk("R3 hit same cycle", n, 0);
      chk("R3 hit no read", dr, 0);
    end
    @(negedge clk); #1;
    chk("R13 no ready when idle", int'(rdy), 0);

    do_flush(0);
    chk("R11 clean flush no writes", dw, 0);
    acc(0, 0, 0, 0);
    chk("R11 invalidated line misses", dr, 1);

    do_flush(0);
    for (int t = 0; t < 4; t++) begin
      acc(0, 0, 8*t, 0);
      chk("R5 fill miss", dr, 1);
    end
    for (int t = 0; t < 4; t++) begin
      acc(0, 0, 8*t, 0);
      chk("R5 empty ways used first", dr, 0);
    end
    acc(0, 0, 0, 0);
    for (int k = 0; k < 8; k++) acc(0, 0, 8, 0);
    acc(0, 0, 32, 0);
    chk("R6 new tag misses", dr, 1);
    chk("R6 clean victim no write", dw, 0);
    acc(0, 0, 16, 0);
    chk("R6 saturated tie keeps way2", dr, 0);
    acc(0, 0, 0, 0);
    chk("R6 lowest tied way evicted", dr, 1);

    do_flush(0);
    for (int t = 0; t < 5; t++) acc(0, 0, 8*t, 0);
    acc(0, 0, 8, 0);
    chk("R6 younger line kept", dr, 0);
    acc(0, 0, 0, 0);
    chk("R6 oldest line evicted", dr, 1);

    do_flush(0);
    acc(0, 1, 1, 16'hBEEF);
    chk("R9 write miss reads line", dr, 1);
    chk("R9 write miss no write", dw, 0);
    acc(0, 0, 1, 0);
    chk("R9 merged word", q, 16'hBEEF);
    chk("R9 merged hit", dr, 0);
    acc(0, 0, 0, 0);
    chk("R9 other word kept", q, seed(0));
    acc(0, 1, 0, 16'h1234);
    chk("R7 write hit same cycle", n, 0);
    chk("R7 write hit no write", dw, 0);
    chk("R7 memory untouched", int'(m0.mem[0]), int'({DW'(seed(1)), DW'(seed(0))}));
    acc(0, 0, 8, 0); acc(0, 0, 16, 0); acc(0, 0, 24, 0);
    acc(0, 0, 32, 0);
    chk("R8 dirty eviction writes", dw, 1);
    chk("R8 written line", int'(m0.mem[0]), int'({16'hBEEF, 16'h1234}));
    acc(0, 0, 40, 0);
    chk("R8 clean eviction no write", dw, 0);

    do_flush(0);
    acc(0, 1, 2, 16'h1111);
    acc(0, 1, 10, 16'h2222);
    acc(0, 0, 4, 0);
    do_flush(0);
    chk("R11 dirty lines written", dw, 2);
    chk("R11 line1 word0", int'(m0.mem[1][15:0]), 16'h1111);
    chk("R11 line5 word0", int'(m0.mem[5][15:0]), 16'h2222);
    acc(0, 0, 2, 0);
    chk("R11 refetch after flush", dr, 1);
    chk("R11 refetched data", q, 16'h1111);

    acc(1, 1, 3, 16'hAAAA);
    chk("R10 write miss reads", dr, 1);
    chk("R10 write miss writes through", dw, 1);
    chk("R10 memory line", int'(m1.mem[1]), int'({16'hAAAA, DW'(seed(2))}));
    acc(1, 1, 2, 16'h5555);
    chk("R10 write hit writes", dw, 1);
    chk("R10 write hit no read", dr, 0);
    chk("R10 stall until ack", int'(n > 0), 1);
    acc(1, 0, 2, 0);
    chk("R10 cached value", q, 16'h5555);
    chk("R10 read hit", n, 0);
    begin
      int wsum = 0;
      for (int t = 1; t < 5; t++) begin acc(1, 0, 2 + 8*t, 0); wsum += dw; end
      chk("R10 evictions never write", wsum, 0);
    end
    acc(1, 0, 2, 0);
    chk("R10 evicted line refetched", dr, 1);
    chk("R10 memory holds write", q, 16'h5555);

    chk("R12 wb request stable", viol[0], 0);
    chk("R12 wt request stable", viol[1], 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule